// File: doc/BRIEF.md
# Subarray-Parallel Bank State Tracker

This block sits in a DRAM controller and mirrors the state of every subarray in every bank of one channel. Each bank is split into subarrays, and each subarray has its own local row buffer and its own latched row, so several subarrays of the same bank can be open at once. A subarray can only move data over the bank's global bitlines when it holds the bank's single designation mark. The tracker keeps, for each subarray, whether it is precharged or activated, which local row it holds, and whether it is the designated one in its bank.

Two paths run side by side. The request path takes a bank and a full row address and classifies the request in the same cycle. It is a hit when the row is open in the designated subarray. It is a switch when the row is open but the subarray is not designated. It needs an activate when its subarray is precharged. It is a conflict when its subarray holds another row, which then needs a precharge followed by an activate. The command path checks each issued command against the tracked state, flags any command that is illegal, and applies the legal ones at the clock edge.

Each subarray slot is a two-state machine. The states are PRECHARGED and ACTIVATED. Transition ACT_OPEN goes from PRECHARGED to ACTIVATED and loads the row. Transition PRE_CLOSE goes from ACTIVATED to PRECHARGED and clears the designation. In ACTIVATED, SEL_MARK sets the designation and SEL_UNMARK clears it when a sibling subarray is selected. A synchronous reset puts every slot in PRECHARGED with no designation.

Top module: `sat_bank_tracker`

## Requirements
- R1: After synchronous reset, every subarray is precharged and undesignated. Every request is then classified as activate, and every READ or WRITE is illegal.
- R2: req_class is combinational on req_bank and req_row, with the encoding 0 = hit, 1 = switch, 2 = activate, 3 = conflict. A precharged subarray gives 2. An activated subarray holding a different local row gives 3. A matching row in a designated subarray gives 0. A matching row in an undesignated subarray gives 1.
- R3: With 9 local row bits, the subarray index is row[ROW_W-1:9] and the local row is row[8:0]. Two rows that share the low 9 bits but differ in the upper bits belong to different subarrays.
- R4: cmd_op 0 (ACTIVATE) on a precharged subarray opens it with the command's local row at the next edge. This holds even while other subarrays of the same bank are open, and no precharge of the bank is needed.
- R5: cmd_op 1 (PRECHARGE) closes the target subarray at the next edge and clears its designation. A PRECHARGE to a subarray that is already precharged is legal and changes nothing.
- R6: cmd_op 2 (SELECT) on an activated subarray designates it and undesignates every other subarray of that bank at the same edge. Other banks are unaffected, and at most one subarray per bank is designated.
- R7: A command is illegal in these cases: ACTIVATE to an activated subarray, SELECT to a precharged subarray, READ (3) or WRITE (4) to a subarray that is not activated, not designated or not holding the command's row, or op codes 5 to 7. For an illegal command, cmd_illegal is high in the same cycle and no state changes.
- R8: A legal READ or WRITE leaves all tracked state unchanged.
- R9: While cmd_valid is low, cmd_illegal is low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | 0 ACTIVATE, 1 PRECHARGE, 2 SELECT, 3 READ, 4 WRITE |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_row | input | ROW_W | Full row address of the command; the upper bits pick the subarray |
| cmd_illegal | output | 1 | The valid command breaks the state rules and is dropped |
| req_bank | input | BANK_W | Bank of the request being classified |
| req_row | input | ROW_W | Full row address of the request |
| req_class | output | 2 | Request class: hit, switch, activate or conflict |

## Verification
req_class and cmd_illegal are combinational, so they are due in the same cycle the inputs are driven. The bench drives inputs just after the falling edge and samples both outputs one nanosecond later. A command's effect on state is due at the next rising edge, so it can first be seen through req_class in the following cycle. The bench's reference model applies a command only after that rising edge, and compares the design against it on every clock, both in a directed sequence and over a long stream of random commands packed into two banks and four subarrays.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_PRE = 3'd1,
        OP_SEL = 3'd2,
        OP_RD  = 3'd3,
        OP_WR  = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_SWITCH   = 2'd1,
        CLS_ACTIVATE = 2'd2,
        CLS_CONFLICT = 2'd3
    } req_class_e;

    typedef enum logic {
        SA_PRECHARGED = 1'b0,
        SA_ACTIVATED  = 1'b1
    } sa_state_e;

endpackage

// File: rtl/sat_slot.sv
module sat_slot
    import sat_pkg::*;
#(
    parameter int LR_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act_en,
    input  logic            pre_en,
    input  logic            sel_en,
    input  logic            desel_en,
    input  logic [LR_W-1:0] act_row,
    output logic            open_o,
    output logic            desig_o,
    output logic [LR_W-1:0] row_o
);

    sa_state_e       st_q, st_d;
    logic            desig_q, desig_d;
    logic [LR_W-1:0] row_q, row_d;

    // next state: ACT_OPEN, PRE_CLOSE, SEL_MARK, SEL_UNMARK
    always_comb begin
        st_d    = st_q;
        row_d   = row_q;
        desig_d = desig_q;
        unique case (st_q)
            SA_PRECHARGED: begin
                if (act_en) begin
                    st_d  = SA_ACTIVATED;
                    row_d = act_row;
                end
            end
            SA_ACTIVATED: begin
                if (pre_en) begin
                    st_d    = SA_PRECHARGED;
                    desig_d = 1'b0;
                end else if (sel_en) begin
                    desig_d = 1'b1;
                end else if (desel_en) begin
                    desig_d = 1'b0;
                end
            end
            default: st_d = SA_PRECHARGED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SA_PRECHARGED;
            desig_q <= 1'b0;
            row_q   <= '0;
        end else begin
            st_q    <= st_d;
            desig_q <= desig_d;
            row_q   <= row_d;
        end
    end

    always_comb begin
        open_o  = (st_q == SA_ACTIVATED);
        desig_o = desig_q;
        row_o   = row_q;
    end

    AST_DESIG_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        desig_q |-> (st_q == SA_ACTIVATED)); // R6

    AST_ACT_LOADS_ROW: assert property (@(posedge clk) disable iff (rst)
        (act_en && st_q == SA_PRECHARGED) |=> (st_q == SA_ACTIVATED && row_q == $past(act_row))); // R4

endmodule

// File: rtl/sat_cmd_check.sv
module sat_cmd_check
    import sat_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       tgt_open,
    input  logic       tgt_desig,
    input  logic       tgt_match,
    output logic       illegal,
    output logic       apply
);

    logic bad;

    always_comb begin
        case (cmd_op)
            OP_ACT:        bad = tgt_open;
            OP_PRE:        bad = 1'b0;
            OP_SEL:        bad = !tgt_open;
            OP_RD, OP_WR:  bad = !(tgt_open && tgt_desig && tgt_match);
            default:       bad = 1'b1;
        endcase
        illegal = cmd_valid && bad;
        apply   = cmd_valid && !bad;
    end

endmodule

// File: rtl/sat_bank_tracker.sv
module sat_bank_tracker
    import sat_pkg::*;
#(
    parameter int NUM_BANKS     = 8,
    parameter int NUM_SUBARRAYS = 8,
    parameter int LR_W          = 9,
    parameter int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int ROW_W         = LR_W + $clog2(NUM_SUBARRAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    output logic              cmd_illegal,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic [1:0]        req_class
);

    localparam int SA_W  = (NUM_SUBARRAYS > 1) ? $clog2(NUM_SUBARRAYS) : 1;
    localparam int NSLOT = NUM_BANKS * NUM_SUBARRAYS;
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [SA_W-1:0]  cmd_sa, req_sa;
    logic [IDX_W-1:0] cmd_idx, req_idx;
    logic [NSLOT-1:0] slot_open, slot_desig;
    logic [LR_W-1:0]  slot_row [NSLOT];
    logic             tgt_open, tgt_desig, tgt_match, cmd_apply;
    req_class_e       cls;

    generate
        if (NUM_SUBARRAYS == 1) begin : g_one_sa
            assign cmd_sa = '0;
            assign req_sa = '0;
        end else begin : g_many_sa
            assign cmd_sa = cmd_row[ROW_W-1:LR_W];
            assign req_sa = req_row[ROW_W-1:LR_W];
        end
    endgenerate

    always_comb begin
        cmd_idx = IDX_W'(int'(cmd_bank) * NUM_SUBARRAYS + int'(cmd_sa));
        req_idx = IDX_W'(int'(req_bank) * NUM_SUBARRAYS + int'(req_sa));
    end

    always_comb begin
        tgt_open  = slot_open[cmd_idx];
        tgt_desig = slot_desig[cmd_idx];
        tgt_match = (slot_row[cmd_idx] == cmd_row[LR_W-1:0]);
    end

    sat_cmd_check u_check (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .tgt_open  (tgt_open),
        .tgt_desig (tgt_desig),
        .tgt_match (tgt_match),
        .illegal   (cmd_illegal),
        .apply     (cmd_apply)
    );

    generate
        for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
            logic hit_slot, hit_bank;
            assign hit_slot = (cmd_idx == IDX_W'(gi));
            assign hit_bank = (cmd_bank == BANK_W'(gi / NUM_SUBARRAYS));

            sat_slot #(.LR_W(LR_W)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .act_en   (cmd_apply && cmd_op == OP_ACT && hit_slot),
                .pre_en   (cmd_apply && cmd_op == OP_PRE && hit_slot),
                .sel_en   (cmd_apply && cmd_op == OP_SEL && hit_slot),
                .desel_en (cmd_apply && cmd_op == OP_SEL && hit_bank && !hit_slot),
                .act_row  (cmd_row[LR_W-1:0]),
                .open_o   (slot_open[gi]),
                .desig_o  (slot_desig[gi]),
                .row_o    (slot_row[gi])
            );
        end

        for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank_chk
            AST_ONE_DESIG: assert property (@(posedge clk) disable iff (rst)
                $onehot0(slot_desig[gb*NUM_SUBARRAYS +: NUM_SUBARRAYS])); // R6
        end
    endgenerate

    // request classification
    always_comb begin
        if (!slot_open[req_idx]) begin
            cls = CLS_ACTIVATE;
        end else if (slot_row[req_idx] != req_row[LR_W-1:0]) begin
            cls = CLS_CONFLICT;
        end else if (slot_desig[req_idx]) begin
            cls = CLS_HIT;
        end else begin
            cls = CLS_SWITCH;
        end
        req_class = cls;
    end

    AST_ILLEGAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cmd_illegal |=> ($stable(slot_open) && $stable(slot_desig))); // R7

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(slot_open) && $stable(slot_desig))); // R9

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cmd_apply && cmd_op == OP_PRE) |=> (!slot_open[$past(cmd_idx)] && !slot_desig[$past(cmd_idx)])); // R5

    AST_IDLE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !cmd_illegal); // R9

endmodule

// File: tb/sat_bank_tracker_bench.sv
`timescale 1ns/1ps
module sat_bank_tracker_bench;

    localparam int NB = 8;
    localparam int NS = 8;
    localparam int LR = 9;
    localparam int BW = 3;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic [RW-1:0] cmd_row = '0;
    logic          cmd_illegal;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [1:0]    req_class;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit m_open  [NB][NS];
    bit m_desig [NB][NS];
    int m_row   [NB][NS];

    always #2 clk = ~clk;

    sat_bank_tracker u_sat_bank_tracker (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_bank    (cmd_bank),
        .cmd_row     (cmd_row),
        .cmd_illegal (cmd_illegal),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_class   (req_class)
    );

    function automatic int exp_class(int b, int row);
        int s, l;
        s = row >> LR;
        l = row & ((1 << LR) - 1);
        if (!m_open[b][s]) return 2;
        if (m_row[b][s] != l) return 3;
        if (m_desig[b][s]) return 0;
        return 1;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // drive one cycle, check the combinational outputs, then apply to the model after the edge
    task automatic step(bit v, int op, int cb, int crow, int qb, int qrow, string ctag);
        int s, l, ecls;
        bit bad, eill;
        string itag;
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_bank  = BW'(cb);
        cmd_row   = RW'(crow);
        req_bank  = BW'(qb);
        req_row   = RW'(qrow);
        #1;
        s = crow >> LR;
        l = crow & ((1 << LR) - 1);
        case (op)
            0:       bad = m_open[cb][s];
            1:       bad = 1'b0;
            2:       bad = !m_open[cb][s];
            3, 4:    bad = !(m_open[cb][s] && m_desig[cb][s] && m_row[cb][s] == l);
            default: bad = 1'b1;
        endcase
        eill = v && bad;
        if (ctag == "R1")      itag = "R1";
        else if (!v)           itag = "R9";
        else if (bad)          itag = "R7";
        else if (op == 0)      itag = "R4";
        else if (op == 1)      itag = "R5";
        else if (op == 2)      itag = "R6";
        else                   itag = "R8";
        ecls = exp_class(qb, qrow);
        check(ctag, "req_class", int'(req_class), ecls);
        check(itag, "cmd_illegal", int'(cmd_illegal), int'(eill));
        @(posedge clk);
        if (v && !bad) begin
            case (op)
                0: begin m_open[cb][s] = 1'b1; m_row[cb][s] = l; end
                1: begin m_open[cb][s] = 1'b0; m_desig[cb][s] = 1'b0; end
                2: begin
                    for (int k = 0; k < NS; k++) m_desig[cb][k] = 1'b0;
                    m_desig[cb][s] = 1'b1;
                end
                default: ;
            endcase
        end
    endtask

    function automatic int rw(int s, int l);
        return s * 512 + l;
    endfunction

    initial begin
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < NS; s++) begin
                m_open[b][s] = 0; m_desig[b][s] = 0; m_row[b][s] = 0;
            end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen through the ports
        for (int b = 0; b < NB; b++) step(1'b1, 3, b, rw(b, 0), b, rw(7 - b, 11), "R1");

        // directed sequence
        step(1'b1, 0, 0, rw(2, 5), 0, rw(2, 5), "R2");   // ACT sa2
        step(1'b0, 0, 0, 0,        0, rw(2, 5), "R2");   // switch
        step(1'b0, 0, 0, 0,        0, rw(2, 6), "R2");   // conflict
        step(1'b1, 2, 0, rw(2, 5), 0, rw(2, 5), "R2");   // SEL sa2
        step(1'b1, 0, 0, rw(3, 7), 0, rw(2, 5), "R2");   // hit; ACT sa3 in parallel
        step(1'b1, 3, 0, rw(2, 5), 0, rw(3, 7), "R2");   // READ legal
        step(1'b1, 4, 0, rw(2, 6), 0, rw(2, 5), "R2");   // WRITE wrong row
        step(1'b1, 2, 0, rw(3, 7), 0, rw(2, 5), "R2");   // SEL sa3
        step(1'b1, 0, 0, rw(2, 9), 0, rw(2, 5), "R2");   // ACT on open sa2
        step(1'b1, 3, 0, rw(2, 5), 0, rw(3, 7), "R2");   // READ undesignated
        step(1'b1, 1, 0, rw(3, 7), 0, rw(3, 7), "R2");   // PRE designated sa3
        step(1'b1, 1, 0, rw(3, 7), 0, rw(3, 7), "R2");   // PRE already precharged
        step(1'b1, 2, 0, rw(3, 0), 0, rw(2, 5), "R2");   // SEL precharged
        step(1'b1, 6, 0, rw(2, 5), 0, rw(2, 5), "R2");   // undefined op
        step(1'b1, 0, 1, rw(5, 3), 0, rw(2, 5), "R3");
        step(1'b1, 2, 1, rw(5, 3), 1, rw(5, 3), "R3");
        step(1'b0, 0, 0, 0,        1, rw(5, 3), "R3");
        step(1'b0, 0, 0, 0,        1, rw(4, 3), "R3");
        step(1'b0, 2, 1, rw(2, 5), 0, rw(2, 5), "R3");   // invalid command ignored

        // random stream over two banks and four subarrays
        for (int n = 0; n < 4000; n++) begin
            int op, cb, cs, cl, qb, qs, ql;
            op = $urandom_range(0, 6);
            cb = $urandom_range(0, 1);
            cs = $urandom_range(0, 3);
            cl = $urandom_range(0, 1);
            qb = $urandom_range(0, 1);
            qs = $urandom_range(0, 3);
            ql = $urandom_range(0, 1);
            step(($urandom_range(0, 7) != 0), op, cb, rw(cs, cl), qb, rw(qs, ql), "R2");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule